// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

A synchronous binary counter whose direction is set by one control line. All state bits step together on the rising clock edge while the active-low enable is asserted. If the enable is deasserted, the count holds. An active-low preset input forces the data inputs onto the count straight away, at any clock level. The state keeps that value once the preset is released. A synchronous active-high reset clears the count.

Two outputs let several counters form a wider one. The terminal flag is a combinational decode of the count and the direction. It is high at the all-ones value when counting up and at zero when counting down. The strobe output is active-low and is asserted only during the low half of the clock, and only while the terminal flag is high and counting is enabled. With a shared clock, the next stage can be enabled from the OR of this stage's enable and the inverted terminal flag. A stage preset to a chosen start value works as a modulo-N divider.

Top module: `updn_counter`

## Requirements
- R1: With the preset input high, a high reset at a rising clock edge sets the count to zero.
- R2: At a rising edge with reset low and the preset input high, an enable of 0 steps the count by one and an enable of 1 leaves it unchanged.
- R3: A direction of 0 increments the count and a direction of 1 decrements it. The all-ones value steps up to zero and zero steps down to all-ones.
- R4: While the preset input is 0, the count output equals the data inputs at once, during either clock phase. After the preset input returns to 1, the count holds that data value until the next counting edge.
- R5: A preset that is held low across a rising edge wins over both counting and reset at that edge.
- R6: The terminal flag is 1 exactly when direction is 0 and the count is all-ones, or when direction is 1 and the count is zero. The enable has no effect on it.
- R7: The strobe output is 0 exactly when the terminal flag is 1, the enable is 0 and the clock is low. Otherwise it is 1.
- R8: Two stages that share a clock and a direction form a counter of twice the width when the upper stage's enable is the OR of the lower stage's enable and the inverted lower terminal flag. This holds through wrap-around in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count steps on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Count enable, active low |
| dir | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Asynchronous preset, active low |
| data | input | W | Preset value |
| count | output | W | Current count |
| tc | output | 1 | Terminal flag for look-ahead cascading |
| ripple_n | output | 1 | Active-low strobe during the low clock phase at the terminal count |

## Verification
The bench uses the default width of 4. That keeps both wrap points and both terminal decodes within reach of short directed runs and a few hundred random cycles. It presets the count in the high and in the low clock phase, and it reverses the direction while the count is sitting at a terminal value. A second pair of width-4 instances is chained into an 8-bit counter. That pair is started just below the carry point and also run through 256 up steps, so that every carry and borrow between the two stages is exercised.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/updn_step.sv
module updn_step #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         dir,
  output logic [W-1:0] nxt
);
  import updn_pkg::*;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (dir_e'(dir) == DIR_DOWN) nxt = cur - ONE;
    else                         nxt = cur + ONE;
  end
endmodule

// File: rtl/updn_term.sv
module updn_term #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         dir,
  output logic         tc
);
  import updn_pkg::*;
  logic all_ones, all_zero;

  assign all_ones = &cur;
  assign all_zero = ~(|cur);
  assign tc = (dir_e'(dir) == DIR_DOWN) ? all_zero : all_ones;
endmodule

// File: rtl/updn_state.sv
module updn_state #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic         load_n,
  input  logic [W-1:0] data,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] state
);
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)    state <= data;
    else if (rst)   state <= '0;
    else if (!en_n) state <= nxt;
  end
endmodule

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic         dir,
  input  logic         load_n,
  input  logic [W-1:0] data,
  output logic [W-1:0] count,
  output logic         tc,
  output logic         ripple_n
);
  logic [W-1:0] state_q;
  logic [W-1:0] step_d;

  updn_step #(.W(W)) u_step (
    .cur (state_q),
    .dir (dir),
    .nxt (step_d)
  );

  updn_state #(.W(W)) u_state (
    .clk    (clk),
    .rst    (rst),
    .en_n   (en_n),
    .load_n (load_n),
    .data   (data),
    .nxt    (step_d),
    .state  (state_q)
  );

  // while preset is held the data inputs pass straight through
  assign count = load_n ? state_q : data;

  updn_term #(.W(W)) u_term (
    .cur (count),
    .dir (dir),
    .tc  (tc)
  );

  assign ripple_n = ~(tc & ~en_n & ~clk);
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         en_n,
  input logic         dir,
  input logic         load_n,
  input logic [W-1:0] data,
  input logic [W-1:0] count,
  input logic         tc,
  input logic         ripple_n
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // set when a preset has occurred since the previous rising edge
  logic seen_load;
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) seen_load <= 1'b1;
    else         seen_load <= 1'b0;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    (rst && load_n) |=> (seen_load || !load_n || count == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (load_n && en_n) |=> (seen_load || !load_n || count == $past(count)));

  assert_up_step_R3: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_n && !dir) |=> (seen_load || !load_n || count == $past(count) + ONE));

  assert_down_step_R3: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_n && dir) |=> (seen_load || !load_n || count == $past(count) - ONE));

  assert_preset_pass_R4: assert property (@(posedge clk)
    !load_n |-> (count == data));

  assert_term_decode_R6: assert property (@(posedge clk) disable iff (rst)
    tc |-> ((dir && count == '0) || (!dir && count == '1)));

  assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (rst)
    !ripple_n |-> (tc && !en_n));
endmodule

bind updn_counter updn_counter_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en_n     (en_n),
  .dir      (dir),
  .load_n   (load_n),
  .data     (data),
  .count    (count),
  .tc       (tc),
  .ripple_n (ripple_n)
);

// File: tb/sim_updn_counter.sv
module sim_updn_counter;
  localparam int W = 4;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_n = 1'b1, dir = 1'b0, load_n = 1'b1;
  logic [W-1:0] data = '0;
  logic [W-1:0] count;
  logic tc, ripple_n;

  // cascade pair
  logic c_en_n = 1'b1, c_dir = 1'b0, c_load_n = 1'b1;
  logic [W-1:0] c_data_lo = '0, c_data_hi = '0;
  logic [W-1:0] cnt_lo, cnt_hi;
  logic tc_lo, tc_hi, rp_lo, rp_hi, en_hi_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [W-1:0] ref_c = '0;
  logic [2*W-1:0] ref8 = '0;

  always #(PERIOD/2) clk = ~clk;

  updn_counter #(.W(W)) u0 (
    .clk(clk), .rst(rst), .en_n(en_n), .dir(dir), .load_n(load_n),
    .data(data), .count(count), .tc(tc), .ripple_n(ripple_n));

  assign en_hi_n = c_en_n | ~tc_lo;

  updn_counter #(.W(W)) uc_lo (
    .clk(clk), .rst(rst), .en_n(c_en_n), .dir(c_dir), .load_n(c_load_n),
    .data(c_data_lo), .count(cnt_lo), .tc(tc_lo), .ripple_n(rp_lo));

  updn_counter #(.W(W)) uc_hi (
    .clk(clk), .rst(rst), .en_n(en_hi_n), .dir(c_dir), .load_n(c_load_n),
    .data(c_data_hi), .count(cnt_hi), .tc(tc_hi), .ripple_n(rp_hi));

  function automatic logic [W-1:0] nxt_val(logic [W-1:0] c, logic d, logic e);
    if (e) return c;
    return d ? c - 1'b1 : c + 1'b1;
  endfunction

  function automatic logic term_of(logic [W-1:0] c, logic d);
    return d ? (c == '0) : (c == '1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // called at posedge+1 (clock high); ends at next posedge+1
  task automatic step(input logic d, input logic e);
    dir = d; en_n = e;
    @(negedge clk); #1;
    chk("R6 terminal flag", tc, term_of(ref_c, d));
    chk("R7 strobe low phase", ripple_n, !(term_of(ref_c, d) && !e));
    chk("R2 count mid-cycle", count, ref_c);
    @(posedge clk);
    ref_c = rst ? '0 : nxt_val(ref_c, d, e);
    #1;
    chk("R3 count after edge", count, ref_c);
    chk("R7 strobe high phase", ripple_n, 1'b1);
  endtask

  task automatic preset_hi(input logic [W-1:0] v);
    data = v; load_n = 1'b0; #1;
    chk("R4 preset high phase pass", count, v);
    #1 load_n = 1'b1; ref_c = v; #1;
    chk("R4 preset high phase held", count, v);
    @(posedge clk);
    ref_c = nxt_val(ref_c, dir, en_n); #1;
    chk("R4 after high preset edge", count, ref_c);
  endtask

  task automatic preset_lo(input logic [W-1:0] v);
    @(negedge clk); #1;
    data = v; load_n = 1'b0; #1;
    chk("R4 preset low phase pass", count, v);
    #1 load_n = 1'b1; ref_c = v; #1;
    chk("R4 preset low phase held", count, v);
    @(posedge clk);
    ref_c = nxt_val(ref_c, dir, en_n); #1;
    chk("R4 after low preset edge", count, ref_c);
  endtask

  task automatic load_across(input logic [W-1:0] v, input logic r);
    en_n = 1'b0; data = v; load_n = 1'b0; rst = r;
    @(posedge clk); #1;
    chk("R5 preset wins at edge", count, v);
    load_n = 1'b1; rst = 1'b0; ref_c = v; #1;
    chk("R5 value kept after release", count, v);
  endtask

  task automatic c_step(input logic d);
    c_dir = d;
    @(negedge clk); #1;
    chk("R8 cascade value", {cnt_hi, cnt_lo}, ref8);
    chk("R8 cascade terminal", tc_hi & tc_lo, d ? (ref8 == '0) : (ref8 == '1));
    @(posedge clk);
    ref8 = d ? ref8 - 1'b1 : ref8 + 1'b1; #1;
    chk("R8 cascade after edge", {cnt_hi, cnt_lo}, ref8);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset clears", count, '0);
    chk("R1 cascade reset", {cnt_hi, cnt_lo}, 8'h00);
    rst = 1'b0; ref_c = '0;

    // hold then up through wrap
    step(1'b0, 1'b1); step(1'b0, 1'b1);
    preset_hi(4'hD);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    // down through wrap at zero
    preset_lo(4'h2);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    // reversal at terminal: sit at all-ones, hold, then flip direction
    en_n = 1'b1; preset_hi(4'hF);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    // preset priority over count and reset
    load_across(4'h9, 1'b0);
    load_across(4'h6, 1'b1);
    // mid-run reset
    rst = 1'b1; step(1'b0, 1'b0); rst = 1'b0;
    chk("R1 mid-run reset", count, '0);

    // random
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 16) == 0) begin
        if ($urandom % 2) preset_hi(W'($urandom));
        else preset_lo(W'($urandom));
      end else begin
        step(1'($urandom), (($urandom % 4) == 0));
      end
    end
    en_n = 1'b1;

    // cascade: start below carry, then full revolution, then borrow
    c_data_lo = 4'hE; c_data_hi = 4'hF; c_load_n = 1'b0; #1;
    chk("R8 cascade preset", {cnt_hi, cnt_lo}, 8'hFE);
    #1 c_load_n = 1'b1; ref8 = 8'hFE; c_en_n = 1'b0; c_dir = 1'b0;
    @(posedge clk); ref8 = ref8 + 1'b1; #1;
    for (int i = 0; i < 260; i++) c_step(1'b0);
    for (int i = 0; i < 40; i++) c_step(1'b1);
    c_en_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule